// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Cache with Software Refill

This block translates 32-bit virtual addresses into physical addresses. The upper half of an address is the virtual page number and the lower half is the page offset. Translations are held in two ways of eight sets. Each entry carries a virtual page number, a physical page number, a 6-bit address space tag and a valid flag. A lookup request selects one set from the page number and compares both ways of that set at once. The result appears one cycle later: either a hit with the translated address, or a trap pulse.

The block does not walk page tables. On a miss it raises a one-cycle trap and records the faulting virtual address and the program counter of the access. A software handler reads those registers and writes the missing mapping back through the refill port. Within a set, a refill fills an empty way first. When both ways are valid, it replaces the way that was used least recently. Entries are tagged with an address space identifier, which the core loads into a control register. A hit requires the tag to match that register, so entries survive context switches. A flush strobe invalidates every entry for systems that do not use the tag.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `paddr` equals the stored 16-bit physical page number in bits 31:16 and the unchanged `lookupVa[15:0]` in bits 15:0.
- R2: An entry whose valid flag is clear never hits. After reset, every entry is invalid, and `respValid`, `hit` and `trap` are 0.
- R3: A lookup strobed at one clock edge drives `respValid` high for exactly the following cycle. In that cycle exactly one of `hit` and `trap` is 1.
- R4: The set index is the concatenation {vpn[13], vpn[1:0]}. Page 0x1234 therefore maps to set 0 and page 0x3204 maps to set 4. Two different pages of the same set can be resident at the same time.
- R5: On a miss, `trap` pulses for one cycle. `badVa` and `excPc` take the lookup's address and PC. Both registers hold their values through hits until the next miss.
- R6: A refill writes its page number, physical page number and tag into the set chosen from the refill page number and marks that entry valid. Later lookups of that page hit.
- R7: When both ways of the target set are valid, a refill replaces the way that was hit or written least recently.
- R8: A refill into a set that has an invalid way writes an invalid way and never evicts a valid entry. Way 0 is filled first when both ways are invalid.
- R9: A hit requires the entry's tag to equal `curAsid`. `curAsid` resets to 0 and loads `asidWrData` at an edge where `asidWrEn` is 1.
- R10: `flushEn` invalidates all entries at that edge. A refill strobed at the same edge is dropped.
- R11: A lookup and a refill at the same edge see the contents from before that edge. If both touch the same set, the refill's replacement-order update wins over the lookup's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVa | input | 32 | Virtual address to translate |
| lookupPc | input | 32 | Program counter of the access |
| asidWrEn | input | 1 | Load the current address space tag |
| asidWrData | input | 6 | New address space tag |
| refillEn | input | 1 | Refill strobe |
| refillVpn | input | 16 | Refill virtual page number |
| refillPpn | input | 16 | Refill physical page number |
| refillAsid | input | 6 | Refill address space tag |
| flushEn | input | 1 | Invalidate all entries |
| respValid | output | 1 | Lookup result valid |
| hit | output | 1 | Translation found |
| trap | output | 1 | Miss trap pulse |
| paddr | output | 32 | Translated physical address |
| excPc | output | 32 | PC of the last missing access |
| badVa | output | 32 | Virtual address of the last miss |
| curAsid | output | 6 | Current address space tag |

## Verification
The bench uses the default configuration of eight sets, two ways and a 6-bit tag. The structure is small enough that every one of the sixteen entries is filled and looked up, with page numbers and physical page numbers derived arithmetically from the set and way number. The same configuration places the replacement-order cases, the empty-way preference, tag mismatch, flush, the 0x1234/0x3204 index split and a same-set lookup-plus-refill collision within a few dozen cycles each.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic lookup;
    logic refill;
    logic flush;
    logic asidLoad;
    logic refillWay;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_dp.sv
module tlb_dp
  import tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 16,
  parameter int PPN_W  = 16,
  parameter int ASID_W = 6,
  parameter int PC_W   = 32,
  parameter int SETS   = 8,
  parameter int IDX_HI = 13,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAYS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strb,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [ASID_W-1:0] asidWrData,
  input  logic [VPN_W-1:0]  refillVpn,
  input  logic [PPN_W-1:0]  refillPpn,
  input  logic [ASID_W-1:0] refillAsid,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [IDX_W-1:0]  rfIdx,
  output logic [WAYS-1:0]   wayHit,
  output logic [WAYS-1:0]   rfValid,
  output logic              respValid,
  output logic              hit,
  output logic              trap,
  output logic [PPN_W+OFF_W-1:0] paddr,
  output logic [PC_W-1:0]   excPc,
  output logic [VA_W-1:0]   badVa,
  output logic [ASID_W-1:0] curAsid
);
  logic [VPN_W-1:0]  lkVpn;
  logic [VPN_W-1:0]  vpnMem  [WAYS][SETS];
  logic [PPN_W-1:0]  ppnMem  [WAYS][SETS];
  logic [ASID_W-1:0] asidMem [WAYS][SETS];
  logic [SETS-1:0]   validMem [WAYS];
  logic [PPN_W-1:0]  hitPpn;
  logic              anyHit;

  assign lkVpn = lookupVa[VA_W-1:OFF_W];
  // Set index: one high page bit over the low page bits
  assign lkIdx = {lkVpn[IDX_HI], lkVpn[IDX_W-2:0]};
  assign rfIdx = {refillVpn[IDX_HI], refillVpn[IDX_W-2:0]};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayHit[w] = validMem[w][lkIdx] && (vpnMem[w][lkIdx] == lkVpn)
                       && (asidMem[w][lkIdx] == curAsid);
    assign rfValid[w] = validMem[w][rfIdx];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validMem[w] <= '0;
      end else if (strb.flush) begin
        validMem[w] <= '0;
      end else if (strb.refill && strb.refillWay == 1'(w)) begin
        validMem[w][rfIdx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strb.refill && strb.refillWay == 1'(w)) begin
        vpnMem[w][rfIdx]  <= refillVpn;
        ppnMem[w][rfIdx]  <= refillPpn;
        asidMem[w][rfIdx] <= refillAsid;
      end
    end
  end

  assign anyHit = |wayHit;
  assign hitPpn = wayHit[1] ? ppnMem[1][lkIdx] : ppnMem[0][lkIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAsid   <= '0;
      respValid <= 1'b0;
      hit       <= 1'b0;
      trap      <= 1'b0;
      paddr     <= '0;
      excPc     <= '0;
      badVa     <= '0;
    end else begin
      if (strb.asidLoad) curAsid <= asidWrData;
      respValid <= strb.lookup;
      hit       <= strb.lookup && anyHit;
      trap      <= strb.lookup && !anyHit;
      if (strb.lookup && anyHit) paddr <= {hitPpn, lookupVa[OFF_W-1:0]};
      if (strb.lookup && !anyHit) begin
        excPc <= lookupPc;
        badVa <= lookupVa;
      end
    end
  end

  // R3: response follows a request by one cycle, with exactly one outcome
  a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.lookup |=> respValid);
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (hit ^ trap));
  // R1: offset passes through unchanged
  a_r1_offset: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lookup && anyHit) |=> paddr[OFF_W-1:0] == $past(lookupVa[OFF_W-1:0]));
  // R5: trap context captured from the missing lookup
  a_r5_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lookup && !anyHit) |=> (badVa == $past(lookupVa) && excPc == $past(lookupPc)));
  // R10: flush leaves no valid entry
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (validMem[0] == '0 && validMem[1] == '0));
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int SETS = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAYS  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             refillEn,
  input  logic             flushEn,
  input  logic             asidWrEn,
  input  logic [IDX_W-1:0] lkIdx,
  input  logic [IDX_W-1:0] rfIdx,
  input  logic [WAYS-1:0]  wayHit,
  input  logic [WAYS-1:0]  rfValid,
  output tlbStrobe_t       strb
);
  // lruWay[s] names the way to replace next in set s
  logic [SETS-1:0] lruWay;
  logic            victim;
  logic            lkUpdate;

  always_comb begin
    if (!rfValid[0])      victim = 1'b0;
    else if (!rfValid[1]) victim = 1'b1;
    else                  victim = lruWay[rfIdx];
  end

  always_comb begin
    strb.lookup    = lookupValid;
    strb.flush     = flushEn;
    strb.refill    = refillEn && !flushEn;
    strb.asidLoad  = asidWrEn;
    strb.refillWay = victim;
  end

  // A lookup hit updates order unless a refill hits the same set
  assign lkUpdate = lookupValid && (|wayHit) && !(strb.refill && rfIdx == lkIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lruWay <= '0;
    end else begin
      if (lkUpdate) lruWay[lkIdx] <= ~wayHit[1];
      if (strb.refill) lruWay[rfIdx] <= ~victim;
    end
  end

  // R8: a refill never overwrites a live entry while an empty way exists
  a_r8_keep_live: assert property (@(posedge clk) disable iff (!rstN)
    (strb.refill && !(&rfValid)) |-> !rfValid[strb.refillWay]);
  // R7/R11: after a refill, the written way is not the next victim
  a_r7_order_after_refill: assert property (@(posedge clk) disable iff (!rstN)
    strb.refill |=> lruWay[$past(rfIdx)] != $past(strb.refillWay));
  // R10: flush and refill never both reach the datapath
  a_r10_flush_wins: assert property (@(posedge clk) disable iff (!rstN)
    flushEn |-> !strb.refill);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 16,
  parameter int PPN_W  = 16,
  parameter int ASID_W = 6,
  parameter int PC_W   = 32,
  parameter int SETS   = 8,
  parameter int IDX_HI = 13,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic              asidWrEn,
  input  logic [ASID_W-1:0] asidWrData,
  input  logic              refillEn,
  input  logic [VPN_W-1:0]  refillVpn,
  input  logic [PPN_W-1:0]  refillPpn,
  input  logic [ASID_W-1:0] refillAsid,
  input  logic              flushEn,
  output logic              respValid,
  output logic              hit,
  output logic              trap,
  output logic [PPN_W+OFF_W-1:0] paddr,
  output logic [PC_W-1:0]   excPc,
  output logic [VA_W-1:0]   badVa,
  output logic [ASID_W-1:0] curAsid
);
  tlbStrobe_t       strb;
  logic [IDX_W-1:0] lkIdx, rfIdx;
  logic [1:0]       wayHit, rfValid;

  tlb_ctrl #(.SETS(SETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .refillEn(refillEn),
    .flushEn(flushEn), .asidWrEn(asidWrEn), .lkIdx(lkIdx), .rfIdx(rfIdx),
    .wayHit(wayHit), .rfValid(rfValid), .strb(strb)
  );

  tlb_dp #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .ASID_W(ASID_W),
    .PC_W(PC_W), .SETS(SETS), .IDX_HI(IDX_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lookupVa(lookupVa), .lookupPc(lookupPc),
    .asidWrData(asidWrData), .refillVpn(refillVpn), .refillPpn(refillPpn),
    .refillAsid(refillAsid), .lkIdx(lkIdx), .rfIdx(rfIdx), .wayHit(wayHit),
    .rfValid(rfValid), .respValid(respValid), .hit(hit), .trap(trap),
    .paddr(paddr), .excPc(excPc), .badVa(badVa), .curAsid(curAsid)
  );
endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVa = '0;
  logic [31:0] lookupPc = '0;
  logic        asidWrEn = 1'b0;
  logic [5:0]  asidWrData = '0;
  logic        refillEn = 1'b0;
  logic [15:0] refillVpn = '0;
  logic [15:0] refillPpn = '0;
  logic [5:0]  refillAsid = '0;
  logic        flushEn = 1'b0;
  logic        respValid, hit, trap;
  logic [31:0] paddr, excPc, badVa;
  logic [5:0]  curAsid;

  int checks = 0;
  int failures = 0;

  tlb_xlate u_dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
    .lookupPc(lookupPc), .asidWrEn(asidWrEn), .asidWrData(asidWrData),
    .refillEn(refillEn), .refillVpn(refillVpn), .refillPpn(refillPpn),
    .refillAsid(refillAsid), .flushEn(flushEn), .respValid(respValid), .hit(hit),
    .trap(trap), .paddr(paddr), .excPc(excPc), .badVa(badVa), .curAsid(curAsid)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Page for set s, tag k: bit13 and bits1:0 carry the set, k in bits 11:4
  function automatic logic [15:0] mkVpn(input int s, input int k);
    logic [15:0] v;
    v = 16'(k) << 4;
    v[13] = s[2];
    v[1:0] = s[1:0];
    return v;
  endfunction

  function automatic logic [15:0] ppnOf(input logic [15:0] v);
    return v ^ 16'h5A5A;
  endfunction

  task automatic refill(input logic [15:0] v, input logic [5:0] a);
    @(negedge clk);
    refillEn = 1'b1; refillVpn = v; refillPpn = ppnOf(v); refillAsid = a;
    @(negedge clk);
    refillEn = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [31:0] pc);
    @(negedge clk);
    lookupValid = 1'b1; lookupVa = va; lookupPc = pc;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic setAsid(input logic [5:0] a);
    @(negedge clk);
    asidWrEn = 1'b1; asidWrData = a;
    @(negedge clk);
    asidWrEn = 1'b0;
  endtask

  task automatic expectHit(input logic [15:0] v, input logic [15:0] off, input string req);
    lookup({v, off}, 32'hC0DE_0000);
    check(respValid && hit && !trap, req, {29'd0, respValid, hit, trap}, 32'd6);
    check(paddr == {ppnOf(v), off}, req, paddr, {ppnOf(v), off});
  endtask

  task automatic expectMiss(input logic [15:0] v, input string req);
    lookup({v, 16'h00F0}, {16'hBEEF, v});
    check(respValid && !hit && trap, req, {29'd0, respValid, hit, trap}, 32'd5);
  endtask

  initial begin
    logic [31:0] savedPc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2/R9: reset state
    check(!respValid && !hit && !trap, "R2 reset outputs", {29'd0, respValid, hit, trap}, 32'd0);
    check(curAsid == 6'd0, "R9 reset asid", 32'(curAsid), 32'd0);
    expectMiss(16'h0000, "R2 empty after reset");
    // R3: response lasts one cycle
    @(negedge clk);
    check(!respValid && !trap, "R3 single-cycle response", {30'd0, respValid, trap}, 32'd0);

    setAsid(6'd5);
    check(curAsid == 6'd5, "R9 asid load", 32'(curAsid), 32'd5);

    // R6/R8/R1/R4: fill all sixteen entries, then look each up
    for (int s = 0; s < 8; s++)
      for (int k = 1; k <= 2; k++) refill(mkVpn(s, k), 6'd5);
    for (int s = 0; s < 8; s++)
      for (int k = 1; k <= 2; k++) expectHit(mkVpn(s, k), 16'(s * 37 + k * 4099), "R6 R1 R4 fill sweep");

    // R5: misses capture context
    for (int s = 0; s < 8; s++) begin
      expectMiss(mkVpn(s, 3), "R5 miss trap");
      check(badVa == {mkVpn(s, 3), 16'h00F0}, "R5 badVa", badVa, {mkVpn(s, 3), 16'h00F0});
      check(excPc == {16'hBEEF, mkVpn(s, 3)}, "R5 excPc", excPc, {16'hBEEF, mkVpn(s, 3)});
    end
    savedPc = excPc;
    expectHit(mkVpn(1, 1), 16'h1111, "R5 hit between misses");
    check(excPc == savedPc, "R5 excPc held over hit", excPc, savedPc);
    @(negedge clk);
    check(!trap, "R5 trap is a pulse", 32'(trap), 32'd0);

    // R7: touch way0 of set 2, refill evicts way1
    expectHit(mkVpn(2, 1), 16'h0002, "R7 touch");
    refill(mkVpn(2, 4), 6'd5);
    expectHit(mkVpn(2, 1), 16'h0003, "R7 recently used kept");
    expectHit(mkVpn(2, 4), 16'h0004, "R7 new entry");
    expectMiss(mkVpn(2, 2), "R7 least recent evicted");

    // R9: tag mismatch misses
    setAsid(6'd9);
    expectMiss(mkVpn(3, 1), "R9 foreign tag misses");
    setAsid(6'd5);
    expectHit(mkVpn(3, 1), 16'h0005, "R9 own tag hits");

    // R10: flush, and a simultaneous refill is dropped
    @(negedge clk);
    flushEn = 1'b1; refillEn = 1'b1; refillVpn = mkVpn(6, 7); refillPpn = ppnOf(mkVpn(6, 7)); refillAsid = 6'd5;
    @(negedge clk);
    flushEn = 1'b0; refillEn = 1'b0;
    for (int s = 0; s < 8; s++) expectMiss(mkVpn(s, 1), "R10 flushed");
    expectMiss(mkVpn(6, 7), "R10 refill dropped under flush");

    // R8: second refill takes the empty way, first entry survives
    refill(mkVpn(3, 8), 6'd5);
    refill(mkVpn(3, 9), 6'd5);
    expectHit(mkVpn(3, 8), 16'h0008, "R8 empty way used");
    expectHit(mkVpn(3, 9), 16'h0009, "R8 both resident");

    // R4: 0x1234 -> set 0, 0x3204 -> set 4; crowding set 0 leaves 0x3204
    refill(16'h1234, 6'd5);
    refill(16'h3204, 6'd5);
    refill(16'h1238, 6'd5);
    refill(16'h1034, 6'd5);
    expectHit(16'h3204, 16'h0ABC, "R4 split index");
    expectHit(16'h1238, 16'h0001, "R4 same set second way");
    expectMiss(16'h1234, "R4 set 0 oldest evicted");

    // R11: same-edge lookup hit and refill on set 5
    refill(mkVpn(5, 1), 6'd5);
    refill(mkVpn(5, 2), 6'd5);
    @(negedge clk);
    lookupValid = 1'b1; lookupVa = {mkVpn(5, 1), 16'h0055}; lookupPc = 32'h0;
    refillEn = 1'b1; refillVpn = mkVpn(5, 3); refillPpn = ppnOf(mkVpn(5, 3)); refillAsid = 6'd5;
    @(negedge clk);
    lookupValid = 1'b0; refillEn = 1'b0;
    check(hit && paddr == {ppnOf(mkVpn(5, 1)), 16'h0055}, "R11 lookup sees old contents", paddr, {ppnOf(mkVpn(5, 1)), 16'h0055});
    expectMiss(mkVpn(5, 1), "R11 refill order wins");
    expectHit(mkVpn(5, 2), 16'h0006, "R11 other way kept");
    expectHit(mkVpn(5, 3), 16'h0007, "R11 refilled entry");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule